// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock. It fetches a word from the instruction port at the current program counter, decodes it, reads two registers and runs the ALU. In the same cycle it either writes a register, stores a word to the data port, or redirects the program counter. The core implements two register-register arithmetic operations (add, sub), a logical OR with an immediate (ori), a word load (lw), a word store (sw), a branch-if-equal (beq) and an absolute jump (j).

Instruction and data memories live outside the core. The instruction port and the data read port are combinational: the surrounding logic returns a word for the address shown in the same cycle. The data write takes effect on the rising clock edge. The register write port is brought out as three outputs, so the register traffic of each cycle can be seen at the pins.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and the register file clears to zero. `imem_addr` shows the program counter.
- R2: Any instruction that is neither a taken beq nor a j advances the program counter by 4 at the next edge.
- R3: Opcode 000000 with funct 100000 (add) or funct 100010 (sub) writes R[rs]+R[rt] or R[rs]-R[rt] to register rd (instruction bits 15:11). rs is bits 25:21 and rt is bits 20:16.
- R4: Opcode 001101 (ori) writes R[rs] OR the zero-extended 16-bit immediate (bits 15:0) to register rt.
- R5: Opcode 100011 (lw) drives `dmem_addr` = R[rs] + sign-extended immediate and writes `dmem_rdata` to register rt.
- R6: Opcode 101011 (sw) drives `dmem_we` high, with `dmem_addr` = R[rs] + sign-extended immediate and `dmem_wdata` = R[rt]. It writes no register. `dmem_we` is never high for any other opcode.
- R7: Opcode 000100 (beq) subtracts R[rt] from R[rs]. When the result is zero, the next PC is PC+4+(sign-extended immediate × 4). Otherwise it is PC+4. beq writes nothing.
- R8: Opcode 000010 (j) sets the next PC to the top 4 bits of PC+4, followed by the 26-bit target field (bits 25:0), followed by two zero bits. j writes nothing.
- R9: Register 0 always reads as zero. A write aimed at it is dropped.
- R10: Any other opcode, and an R-type word with any other funct, writes neither register nor memory. It only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Program counter / instruction fetch address |
| imem_data | input | 32 | Instruction word at `imem_addr` (combinational) |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (R[rt]) |
| dmem_we | output | 1 | Store enable, written at the rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr` (combinational) |
| wb_we | output | 1 | Register write enable this cycle |
| wb_addr | output | 5 | Register write index |
| wb_data | output | 32 | Register write value |

## Verification
The bound assertions watch several properties in every cycle:
- the reset value of the PC and the +4 step for ordinary instructions;
- the jump target, and the fall-through of an untaken branch;
- that stores happen only for the store opcode and never together with a register write;
- that unknown encodings stay silent;
- that register 0 reads as zero.

Some behaviour can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. These are the actual arithmetic results written back, zero-extension against sign-extension, load data routing, taken-branch targets including a backward branch, and the loss of a write aimed at register 0.

// File: rtl/sc_pkg.sv
package sc_pkg;
  parameter int XLEN = 32;
  parameter int NREG = 32;
  parameter int IMMW = 16;
  parameter int JTW  = 26;
  localparam int RAW = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    sign_ext;
    logic    load_wb;
    logic    reg_wr;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] ext_imm(input logic [IMMW-1:0] imm, input logic sgn);
    return sgn ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : {{(XLEN-IMMW){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_op_e op, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] next_pc(input logic [XLEN-1:0] pc, input logic take_br,
                                              input logic take_j, input logic [XLEN-1:0] offs,
                                              input logic [JTW-1:0] tgt);
    logic [XLEN-1:0] seq;
    seq = pc + XLEN'(4);
    if (take_j)       return {seq[XLEN-1:JTW+2], tgt, 2'b00};
    else if (take_br) return seq + {offs[XLEN-3:0], 2'b00};
    else              return seq;
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  logic is_rt, is_add, is_sub, is_ori, is_lw, is_sw, is_beq, is_j;

  always_comb begin
    is_rt  = (opcode == OP_RTYPE);
    is_add = is_rt && (funct == FN_ADD);
    is_sub = is_rt && (funct == FN_SUB);
    is_ori = (opcode == OP_ORI);
    is_lw  = (opcode == OP_LW);
    is_sw  = (opcode == OP_SW);
    is_beq = (opcode == OP_BEQ);
    is_j   = (opcode == OP_J);
  end

  always_comb begin
    ctrl.dst_is_rd = is_add | is_sub;
    ctrl.b_is_imm  = is_ori | is_lw | is_sw;
    ctrl.sign_ext  = is_lw | is_sw;
    ctrl.load_wb   = is_lw;
    ctrl.reg_wr    = is_add | is_sub | is_ori | is_lw;
    ctrl.mem_wr    = is_sw;
    ctrl.branch    = is_beq;
    ctrl.jump      = is_j;
    if (is_sub | is_beq) ctrl.alu_op = ALU_SUB;
    else if (is_ori)     ctrl.alu_op = ALU_OR;
    else                 ctrl.alu_op = ALU_ADD;
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  ra_a,
  input  logic [RAW-1:0]  ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [RAW-1:0]  wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      always_ff @(posedge clk) regs[g] <= '0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst)                           regs[g] <= '0;
        else if (we && (wa == RAW'(g)))    regs[g] <= wd;
      end
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            zero
);
  assign res  = alu_calc(op, a, b);
  assign zero = (res == '0);
endmodule

// File: rtl/sc_pc.sv
module sc_pc
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            branch,
  input  logic            zero,
  input  logic            jump,
  input  logic [XLEN-1:0] offs,
  input  logic [JTW-1:0]  tgt,
  output logic [XLEN-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= next_pc(pc, branch && zero, jump, offs, tgt);
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            wb_we,
  output logic [RAW-1:0]  wb_addr,
  output logic [XLEN-1:0] wb_data
);
  ctrl_t           ctrl;
  logic [RAW-1:0]  f_rs, f_rt, f_rd;
  logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_res;
  logic            alu_zero;

  assign f_rs = imem_data[25:21];
  assign f_rt = imem_data[20:16];
  assign f_rd = imem_data[15:11];

  sc_decode u_dec (.opcode(imem_data[31:26]), .funct(imem_data[5:0]), .ctrl(ctrl));

  sc_regfile u_rf (
    .clk(clk), .rst(rst), .ra_a(f_rs), .ra_b(f_rt), .rd_a(rs_val), .rd_b(rt_val),
    .we(wb_we), .wa(wb_addr), .wd(wb_data)
  );

  assign imm_x = ext_imm(imem_data[IMMW-1:0], ctrl.sign_ext);
  assign alu_b = ctrl.b_is_imm ? imm_x : rt_val;

  sc_alu u_alu (.op(ctrl.alu_op), .a(rs_val), .b(alu_b), .res(alu_res), .zero(alu_zero));

  sc_pc u_pc (
    .clk(clk), .rst(rst), .branch(ctrl.branch), .zero(alu_zero), .jump(ctrl.jump),
    .offs(ext_imm(imem_data[IMMW-1:0], 1'b1)), .tgt(imem_data[JTW-1:0]), .pc(imem_addr)
  );

  assign dmem_addr  = alu_res;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_wr;
  assign wb_we      = ctrl.reg_wr;
  assign wb_addr    = ctrl.dst_is_rd ? f_rd : f_rt;
  assign wb_data    = ctrl.load_wb ? dmem_rdata : alu_res;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic            dmem_we,
  input logic            wb_we,
  input logic [RAW-1:0]  rs_addr,
  input logic [XLEN-1:0] rs_data,
  input logic            alu_zero
);
  logic is_beq, is_j, known;
  assign is_beq = (instr[31:26] == OP_BEQ);
  assign is_j   = (instr[31:26] == OP_J);
  assign known  = (instr[31:26] == OP_RTYPE && (instr[5:0] == FN_ADD || instr[5:0] == FN_SUB))
               || instr[31:26] == OP_ORI || instr[31:26] == OP_LW || instr[31:26] == OP_SW
               || is_beq || is_j;

  a_r1_pc_reset: assert property (@(posedge clk) rst |=> pc == '0);

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (!is_j && !(is_beq && alu_zero)) |=> pc == $past(pc) + XLEN'(4));

  a_r7_beq_fall: assert property (@(posedge clk) disable iff (rst)
    (is_beq && !alu_zero) |=> pc == $past(pc) + XLEN'(4));

  a_r8_jump_tgt: assert property (@(posedge clk) disable iff (rst)
    is_j |=> pc == {$past(pc[XLEN-1:28] + 4'(pc[27:0] >= 28'hFFFFFFC)), $past(instr[25:0]), 2'b00});

  a_r6_store_only_sw: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> instr[31:26] == OP_SW);

  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !wb_we);

  a_r10_unknown_silent: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!wb_we && !dmem_we));

  a_r9_zero_reads: assert property (@(posedge clk) disable iff (rst)
    rs_addr == '0 |-> rs_data == '0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(imem_addr), .instr(imem_data), .dmem_we(dmem_we),
  .wb_we(wb_we), .rs_addr(f_rs), .rs_data(rs_val), .alu_zero(alu_zero)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, wb_data;
  logic        dmem_we, wb_we;
  logic [4:0]  wb_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] mdm  [64];
  logic [31:0] mreg [32];
  logic [31:0] mpc;

  always #4ns clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compares one cycle against the model, then advances the model.
  task automatic step_model();
    logic [31:0] ins, a, b, sx, zx, res, npc;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    bit          ew, known;
    int          wa;
    string       tag;
    ins = imem[mpc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = mreg[rs]; b = mreg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0, ins[15:0]};
    npc = mpc + 4;
    ew = 0; wa = 0; res = '0; known = 1; tag = "R10";
    if (op == 6'b000000 && fn == 6'b100000)      begin ew = 1; wa = rd; res = a + b; tag = "R3"; end
    else if (op == 6'b000000 && fn == 6'b100010) begin ew = 1; wa = rd; res = a - b; tag = "R3"; end
    else if (op == 6'b001101) begin ew = 1; wa = rt; res = a | zx; tag = "R4"; end
    else if (op == 6'b100011) begin ew = 1; wa = rt; res = mdm[(a + sx) >> 2 & 63]; tag = "R5"; end
    else if (op == 6'b101011) tag = "R6";
    else if (op == 6'b000100) begin tag = "R7"; if (a == b) npc = mpc + 4 + (sx << 2); end
    else if (op == 6'b000010) begin tag = "R8"; npc = {npc[31:28], ins[25:0], 2'b00}; end
    else known = 0;
    if (!known) tag = "R10";

    check(ew || !known ? tag : "R2", imem_addr, mpc);
    check(tag, 32'(wb_we), 32'(ew));
    if (ew) begin
      check(tag, 32'(wb_addr), 32'(wa));
      check(wa == 0 ? "R9" : tag, wb_data, res);
    end
    check(tag, 32'(dmem_we), 32'(op == 6'b101011));
    if (op == 6'b101011 || op == 6'b100011) check(tag, dmem_addr, a + sx);
    if (op == 6'b101011) begin
      check(rt == 0 ? "R9" : "R6", dmem_wdata, b);
      mdm[(a + sx) >> 2 & 63] = b;
    end
    if (ew && wa != 0) mreg[wa] = res;
    mpc = npc;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = {6'b111111, 26'h0};
      dmem[i] = 32'hA5A50000 + 32'(i);
      mdm[i]  = 32'hA5A50000 + 32'(i);
    end
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mpc = '0;
    imem[0]  = enc_i(6'b001101, 0, 1, 16'h00F0);      // ori r1 (R4)
    imem[1]  = enc_i(6'b001101, 0, 2, 16'hFFFF);      // ori zero-ext (R4)
    imem[2]  = enc_r(1, 2, 3, 6'b100000);             // add (R3)
    imem[3]  = enc_r(1, 2, 4, 6'b100010);             // sub negative (R3)
    imem[4]  = enc_i(6'b101011, 0, 3, 16'h0010);      // sw (R6)
    imem[5]  = enc_i(6'b100011, 1, 5, 16'hFF20);      // lw negative offset (R5)
    imem[6]  = enc_r(1, 2, 0, 6'b100000);             // add to r0 (R9)
    imem[7]  = enc_i(6'b101011, 0, 0, 16'h0014);      // sw r0 (R9)
    imem[8]  = enc_i(6'b000100, 3, 5, 16'h0001);      // beq taken (R7)
    imem[9]  = enc_i(6'b001101, 0, 6, 16'h0BAD);      // skipped
    imem[10] = enc_i(6'b000100, 1, 2, 16'h0005);      // beq not taken (R7)
    imem[11] = {6'b111111, 26'h3FFFFFF};              // unknown opcode (R10)
    imem[12] = enc_r(1, 2, 7, 6'b000000);             // unknown funct (R10)
    imem[13] = {6'b000010, 26'd16};                   // j (R8)
    imem[14] = enc_i(6'b001101, 0, 6, 16'h0BAD);
    imem[15] = enc_i(6'b001101, 0, 6, 16'h0BAD);
    imem[16] = enc_i(6'b100011, 0, 6, 16'h0014);      // lw stored zero (R9)
    imem[17] = enc_r(0, 1, 7, 6'b100010);             // sub from r0 (R3)
    imem[18] = enc_i(6'b100011, 0, 8, 16'h0020);      // lw preset word (R5)
    imem[19] = enc_i(6'b000100, 0, 0, 16'hFFFF);      // beq to self (R7)

    repeat (3) @(negedge clk);
    check("R1", imem_addr, 32'h0);
    rst = 1'b0;
    #1ns;
    for (int c = 0; c < 40; c++) begin
      step_model();
      @(negedge clk);
      #1ns;
    end
    rst = 1'b1;
    @(negedge clk);
    check("R1", imem_addr, 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 8ns);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule